// File: doc/BRIEF.md
# Throttle Priority Arbiter

This block sits between several throttle request sources and the clock pulse skippers that slow the processor and graphics clocks. Three sources are handled: a light thermal event, a heavy thermal event and an overcurrent event. Each source holds its own configuration: a priority, a processor clock skip depth given as a percentage, and a graphics skip level given as a 2-bit code. Software programs that configuration through a simple write port. The thermal and overcurrent logic drives one active flag per source.

On every cycle the block looks at the active sources and picks the one with the largest priority. On the next clock edge it presents that source's processor percentage and graphics level, together with a valid flag. Equal priorities are resolved in favour of the lower source index, so the outcome is always defined. When no source is active, the outputs fall back to no throttling. Priority and percentage values are clamped into their legal ranges as they are written, so an out-of-range write can never turn into an illegal setting downstream.

Top module: `throttle_arbiter`

## Requirements
- R1: After reset the outputs are cpu_skip_pct = 0, gpu_skip_lvl = 0 and throttle_valid = 0. Every source's configuration resets to priority 1, percentage 0 and level 0.
- R2: When exactly one source is active, the outputs carry that source's programmed percentage and level, and throttle_valid = 1.
- R3: When several sources are active, the outputs carry the settings of the active source with the numerically largest priority. A larger value means higher priority.
- R4: When active sources share the largest priority, the source with the lowest index wins. Index 0 is light, 1 is heavy and 2 is overcurrent.
- R5: When no source is active, the outputs are cpu_skip_pct = 0, gpu_skip_lvl = 0 and throttle_valid = 0.
- R6: The outputs are registered. A change on src_active appears on the outputs at the first rising edge after the change. A configuration write accepted at one edge affects the outputs at the following edge.
- R7: A priority write below 1 stores 1, and a priority write above 100 stores 100. Values from 1 to 100 are stored unchanged.
- R8: A percentage write above 100 stores 100, and values from 0 to 100 are stored unchanged. cpu_skip_pct therefore never exceeds 100.
- R9: The graphics level is a 2-bit code passed through unchanged: 0 means none (0%), 1 low (50%), 2 medium (75%) and 3 high (85%).
- R10: A write whose cfg_sel is not a valid source index (3 or more) changes no source's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_active | input | 3 | Per-source request flags (bit 0 light, bit 1 heavy, bit 2 overcurrent) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Source index being written |
| cfg_prio | input | 8 | Priority to store (clamped to 1..100) |
| cfg_cpu_pct | input | 8 | Processor skip percentage to store (clamped to 0..100) |
| cfg_gpu_lvl | input | 2 | Graphics skip level code to store |
| cpu_skip_pct | output | 7 | Selected processor skip percentage |
| gpu_skip_lvl | output | 2 | Selected graphics skip level code |
| throttle_valid | output | 1 | High when any source was active on the previous cycle |

## Verification
The bench builds the block with its default parameters: three sources, 8-bit priority and percentage write fields, and a 7-bit percentage output. The 2-bit source select leaves index 3 unused, so a write to that index can be tried and its absence of effect observed through arbitration. The 8-bit write fields can carry 0, 101, 200 and 255, which puts both ends of the clamps within reach. The clamped priorities are arranged so that only a correct clamp combined with the lowest-index tie rule yields the expected winner.

// File: rtl/throttle_arbiter.sv
module throttle_arbiter #(
  parameter int NUM_SRC  = 3,
  parameter int PRIO_W   = 8,
  parameter int PCT_W    = 7,
  parameter int PRIO_MIN = 1,
  parameter int PRIO_MAX = 100,
  parameter int PCT_MAX  = 100,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_active,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic [PCT_W:0]     cfg_cpu_pct,
  input  logic [1:0]         cfg_gpu_lvl,
  output logic [PCT_W-1:0]   cpu_skip_pct,
  output logic [1:0]         gpu_skip_lvl,
  output logic               throttle_valid
);

  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic [PCT_W-1:0]  pct_q  [NUM_SRC];
  logic [1:0]        lvl_q  [NUM_SRC];

  logic [PRIO_W-1:0] prio_in;
  logic [PCT_W-1:0]  pct_in;

  assign prio_in = (cfg_prio < PRIO_W'(PRIO_MIN)) ? PRIO_W'(PRIO_MIN) :
                   (cfg_prio > PRIO_W'(PRIO_MAX)) ? PRIO_W'(PRIO_MAX) : cfg_prio;
  assign pct_in  = (cfg_cpu_pct > (PCT_W+1)'(PCT_MAX)) ? PCT_W'(PCT_MAX)
                                                       : cfg_cpu_pct[PCT_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q[i] <= PRIO_W'(PRIO_MIN);
        pct_q[i]  <= '0;
        lvl_q[i]  <= '0;
      end else if (cfg_we && cfg_sel == SEL_W'(i)) begin
        prio_q[i] <= prio_in;
        pct_q[i]  <= pct_in;
        lvl_q[i]  <= cfg_gpu_lvl;
      end
    end
  end

  logic              win_found;
  logic [PRIO_W-1:0] win_prio;
  logic [PCT_W-1:0]  win_pct;
  logic [1:0]        win_lvl;

  always_comb begin
    win_found = 1'b0;
    win_prio  = '0;
    win_pct   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_active[i] && (!win_found || prio_q[i] > win_prio)) begin
        win_found = 1'b1;
        win_prio  = prio_q[i];
        win_pct   = pct_q[i];
        win_lvl   = lvl_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_skip_pct   <= '0;
      gpu_skip_lvl   <= '0;
      throttle_valid <= 1'b0;
    end else begin
      cpu_skip_pct   <= win_pct;
      gpu_skip_lvl   <= win_lvl;
      throttle_valid <= win_found;
    end
  end

endmodule

module throttle_arbiter_chk #(
  parameter int NUM_SRC = 3,
  parameter int PCT_W   = 7,
  parameter int PCT_MAX = 100
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_active,
  input logic               cfg_we,
  input logic [PCT_W-1:0]   cpu_skip_pct,
  input logic [1:0]         gpu_skip_lvl,
  input logic               throttle_valid
);

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active == '0) |=> (!throttle_valid && cpu_skip_pct == '0 && gpu_skip_lvl == '0));

  // R2
  valid_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active != '0) |=> throttle_valid);

  // R8
  pct_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_skip_pct <= PCT_W'(PCT_MAX));

  // R6
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(src_active) && !cfg_we && !$past(cfg_we)) |=>
      $stable({cpu_skip_pct, gpu_skip_lvl, throttle_valid}));

endmodule

bind throttle_arbiter throttle_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .PCT_W(PCT_W), .PCT_MAX(PCT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_active(src_active), .cfg_we(cfg_we),
  .cpu_skip_pct(cpu_skip_pct), .gpu_skip_lvl(gpu_skip_lvl),
  .throttle_valid(throttle_valid)
);

// File: tb/tb_throttle_arbiter.sv
module tb_throttle_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_active = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_prio = '0;
  logic [7:0] cfg_cpu_pct = '0;
  logic [1:0] cfg_gpu_lvl = '0;
  logic [6:0] cpu_skip_pct;
  logic [1:0] gpu_skip_lvl;
  logic       throttle_valid;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  throttle_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_active(src_active), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_prio(cfg_prio), .cfg_cpu_pct(cfg_cpu_pct),
    .cfg_gpu_lvl(cfg_gpu_lvl), .cpu_skip_pct(cpu_skip_pct),
    .gpu_skip_lvl(gpu_skip_lvl), .throttle_valid(throttle_valid)
  );

  task automatic check(string req, int pct, int lvl, bit vld);
    vectors++;
    if (cpu_skip_pct != 7'(pct) || gpu_skip_lvl != 2'(lvl) || throttle_valid != vld) begin
      miscompares++;
      $display("FAIL %s: got pct=%0d lvl=%0d valid=%0b, expected pct=%0d lvl=%0d valid=%0b",
               req, cpu_skip_pct, gpu_skip_lvl, throttle_valid, pct, lvl, vld);
    end
  endtask

  task automatic wr(int sel, int prio, int pct, int lvl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_prio = 8'(prio);
    cfg_cpu_pct = 8'(pct); cfg_gpu_lvl = 2'(lvl);
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic act(logic [2:0] v);
    @(negedge clk);
    src_active = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 outputs in reset", 0, 0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", 0, 0, 1'b0);
    act(3'b010);
    check("R1 default config", 0, 0, 1'b1);
    act(3'b000);
  endtask

  task automatic t_single();
    wr(0, 10, 25, 1);
    wr(1, 90, 85, 3);
    wr(2, 50, 75, 2);
    act(3'b001); check("R2 light alone", 25, 1, 1'b1);
    act(3'b010); check("R2 R9 heavy alone", 85, 3, 1'b1);
    act(3'b100); check("R2 R9 overcurrent alone", 75, 2, 1'b1);
  endtask

  task automatic t_multi();
    act(3'b101); check("R3 light+oc", 75, 2, 1'b1);
    act(3'b011); check("R3 light+heavy", 85, 3, 1'b1);
    act(3'b111); check("R3 all", 85, 3, 1'b1);
    act(3'b110); check("R3 heavy+oc", 85, 3, 1'b1);
  endtask

  task automatic t_idle();
    act(3'b000); check("R5 none active", 0, 0, 1'b0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    src_active = 3'b001;
    #1 check("R6 before edge", 0, 0, 1'b0);
    @(negedge clk);
    check("R6 after one edge", 25, 1, 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_prio = 8'd10; cfg_cpu_pct = 8'd40; cfg_gpu_lvl = 2'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R6 write not yet visible", 25, 1, 1'b1);
    @(negedge clk);
    check("R6 write visible", 40, 1, 1'b1);
    act(3'b000);
  endtask

  task automatic t_tie();
    wr(2, 90, 75, 2);
    act(3'b110); check("R4 heavy vs oc tie", 85, 3, 1'b1);
    wr(0, 90, 40, 1);
    act(3'b111); check("R4 three-way tie", 40, 1, 1'b1);
    act(3'b000);
  endtask

  task automatic t_clamp();
    wr(0, 0, 40, 1);
    wr(1, 1, 85, 3);
    act(3'b011); check("R7 low clamp gives tie", 40, 1, 1'b1);
    act(3'b000);
    wr(1, 200, 85, 3);
    wr(0, 100, 40, 1);
    act(3'b011); check("R7 high clamp gives tie", 40, 1, 1'b1);
    act(3'b000);
  endtask

  task automatic t_pct();
    wr(2, 90, 255, 2);
    act(3'b100); check("R8 pct 255 clamped", 100, 2, 1'b1);
    wr(2, 90, 101, 2);
    check("R8 pct 101 clamped", 100, 2, 1'b1);
    wr(2, 90, 99, 2);
    check("R8 pct 99 kept", 99, 2, 1'b1);
    act(3'b000);
  endtask

  task automatic t_badsel();
    wr(3, 100, 7, 0);
    act(3'b001); check("R10 light unchanged", 40, 1, 1'b1);
    act(3'b010); check("R10 heavy unchanged", 85, 3, 1'b1);
    act(3'b100); check("R10 oc unchanged", 99, 2, 1'b1);
    act(3'b111); check("R10 R4 all active", 40, 1, 1'b1);
    act(3'b000);
    wr(2, 90, 60, 0);
    act(3'b100); check("R9 level none", 60, 0, 1'b1);
    act(3'b000); check("R5 back to idle", 0, 0, 1'b0);
  endtask

  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_idle();
    t_timing();
    t_tie();
    t_clamp();
    t_pct();
    t_badsel();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule